// File: doc/BRIEF.md
# Dual-Rail Latched Fault Supervisor

This block watches two switching-regulator rails through flags raised by analog comparators and decides when both rails must be forced off. For each rail it receives an overvoltage flag, a severe-undervoltage flag, and a power-good dip flag. It also receives a per-rail undervoltage enable from the start-up sequencer, an over-temperature flag, an active-low shutdown input, a run input, and an input-supply-low flag. The thresholds and hysteresis belong to the comparators and are outside this block.

An overvoltage on either rail latches both rails off and keeps both synchronous rectifiers forced on. A severe undervoltage latches both rails off with the rectifiers left alone, but only on a rail whose blanking delay has expired. A dip requests power-good low without any shutdown. Over-temperature forces the rails off only while its flag is set. A latched fault is cleared by a falling-then-rising toggle of the shutdown or run input, or by the input-supply-low flag. Every input passes through a two-flop synchronizer, and every output is registered.

Top module: `rail_fault_supervisor`

## Requirements
- R1: An overvoltage flag on either rail latches rails_off=1, sr_force_on=1 and fault_code=01.
- R2: A severe-undervoltage flag on a rail whose uv_en bit is 1 latches rails_off=1 and fault_code=10, and leaves sr_force_on=0.
- R3: A severe-undervoltage flag on a rail whose uv_en bit is 0 has no effect on any output.
- R4: pg_low is 1 whenever any dip flag is set or rails_off is 1, and 0 otherwise. A dip alone never sets rails_off.
- R5: A latched fault (fault_code 01 or 10) and its outputs stay unchanged after the fault flags clear.
- R6: shdn_n falling and then rising clears the latched fault. The fall alone does not clear it.
- R7: run_a falling and then rising clears the latched fault.
- R8: While vin_low is 1, no fault latches, and sr_force_on and the latched codes stay cleared.
- R9: Over-temperature sets rails_off=1 with fault_code=11 only while the flag is set, provided no fault is latched. The outputs return to 0 when the flag clears.
- R10: When overvoltage and enabled undervoltage arrive in the same cycle, fault_code=01 and sr_force_on=1.
- R11: fault_code keeps the first latched fault. A later overvoltage still sets sr_force_on=1.
- R12: During reset, fault_code=00, rails_off=0, sr_force_on=0 and pg_low=1.
- R13: An input change shows at the outputs on the third rising clock edge after it is applied: two synchronizer flops, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_flag | input | N_RAILS | Per-rail overvoltage comparator flag |
| uvs_flag | input | N_RAILS | Per-rail severe-undervoltage comparator flag |
| dip_flag | input | N_RAILS | Per-rail power-good dip flag |
| uv_en | input | N_RAILS | Per-rail undervoltage enable (blanking expired) |
| otemp | input | 1 | Over-temperature flag |
| shdn_n | input | 1 | Active-low shutdown control |
| run_a | input | 1 | Run control |
| vin_low | input | 1 | Input-supply collapse flag |
| fault_code | output | 2 | 00 none, 01 overvoltage, 10 undervoltage, 11 thermal |
| rails_off | output | 1 | Force both rails off |
| sr_force_on | output | 1 | Force synchronous rectifiers on |
| pg_low | output | 1 | Request power-good low |

## Verification
On every cycle, the assertions check the relation between the synchronized flags and the registered outputs one cycle later. They cover latching on overvoltage and on enabled undervoltage, the masking of undervoltage on rails that are not enabled, dips driving pg_low, holding of a latched code, clearing under vin_low, thermal follow and release, and overvoltage winning a tie. Some behaviours only the bench scenarios can show. These are that a fall of shdn_n alone leaves the latch in place while the full toggle clears it, that the first fault's code survives a later one, the reset values, and the exact three-edge latency from pin to output.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_OVER  = 2'b01,
        FC_UNDER = 2'b10,
        FC_THERM = 2'b11
    } fault_code_e;

    typedef struct packed {
        fault_code_e lat;
        fault_code_e code;
        logic        sr;
        logic        off;
        logic        pgl;
    } sup_state_t;
endpackage

// File: rtl/rfs_sync.sv
module rfs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rfs_toggle_det.sv
module rfs_toggle_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic         clr_pulse
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] armed;
    } tog_state_t;

    tog_state_t st_d, st_q;
    logic [N-1:0] fell, rose;

    always_comb begin
        fell       = st_q.prev & ~lvl;
        rose       = ~st_q.prev & lvl;
        st_d.prev  = lvl;
        st_d.armed = (st_q.armed | fell) & ~rose;
        clr_pulse  = |(rose & st_q.armed);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
    import rfs_pkg::*;
#(
    parameter int N_RAILS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] ov_flag,
    input  logic [N_RAILS-1:0] uvs_flag,
    input  logic [N_RAILS-1:0] dip_flag,
    input  logic [N_RAILS-1:0] uv_en,
    input  logic               otemp,
    input  logic               shdn_n,
    input  logic               run_a,
    input  logic               vin_low,
    output logic [1:0]         fault_code,
    output logic               rails_off,
    output logic               sr_force_on,
    output logic               pg_low
);
    localparam int SYNC_W = 4 * N_RAILS + 4;
    localparam int OFS_OV = 3 * N_RAILS + 4;
    localparam int OFS_UV = 2 * N_RAILS + 4;
    localparam int OFS_DP = N_RAILS + 4;
    localparam int OFS_EN = 4;

    logic [SYNC_W-1:0]  raw_bus, syn_bus;
    logic [N_RAILS-1:0] ov_s, uvs_s, dip_s, uv_en_s;
    logic               otemp_s, shdn_n_s, run_a_s, vin_low_s;
    logic               ctrl_clr;
    logic               any_ov, any_uv, latched;
    sup_state_t         st_d, st_q;

    assign raw_bus = {ov_flag, uvs_flag, dip_flag, uv_en, otemp, shdn_n, run_a, vin_low};

    rfs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_bus),
        .dout (syn_bus)
    );

    assign ov_s      = syn_bus[OFS_OV +: N_RAILS];
    assign uvs_s     = syn_bus[OFS_UV +: N_RAILS];
    assign dip_s     = syn_bus[OFS_DP +: N_RAILS];
    assign uv_en_s   = syn_bus[OFS_EN +: N_RAILS];
    assign otemp_s   = syn_bus[3];
    assign shdn_n_s  = syn_bus[2];
    assign run_a_s   = syn_bus[1];
    assign vin_low_s = syn_bus[0];

    rfs_toggle_det #(.N(2)) u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      ({shdn_n_s, run_a_s}),
        .clr_pulse(ctrl_clr)
    );

    always_comb begin
        st_d   = st_q;
        any_ov = |ov_s;
        any_uv = |(uvs_s & uv_en_s);
        if (vin_low_s || ctrl_clr) begin
            st_d.lat = FC_NONE;
            st_d.sr  = 1'b0;
        end else begin
            if (st_q.lat == FC_NONE) begin
                if (any_ov)      st_d.lat = FC_OVER;
                else if (any_uv) st_d.lat = FC_UNDER;
            end
            if (any_ov) st_d.sr = 1'b1;
        end
        latched   = (st_d.lat != FC_NONE);
        st_d.off  = latched | otemp_s;
        st_d.code = latched ? st_d.lat : (otemp_s ? FC_THERM : FC_NONE);
        st_d.pgl  = st_d.off | (|dip_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pgl  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_code  = st_q.code;
    assign rails_off   = st_q.off;
    assign sr_force_on = st_q.sr;
    assign pg_low      = st_q.pgl;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int N_RAILS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_RAILS-1:0] ov_s,
    input logic [N_RAILS-1:0] uvs_s,
    input logic [N_RAILS-1:0] uv_en_s,
    input logic [N_RAILS-1:0] dip_s,
    input logic               otemp_s,
    input logic               vin_low_s,
    input logic               ctrl_clr,
    input logic [1:0]         fault_code,
    input logic               rails_off,
    input logic               sr_force_on,
    input logic               pg_low
);
    AST_OV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|ov_s && !vin_low_s && !ctrl_clr) |=> (rails_off && sr_force_on)); // R1

    AST_UV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|(uvs_s & uv_en_s) && !vin_low_s && !ctrl_clr) |=> rails_off); // R2

    AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rails_off && !(|ov_s) && !(|(uvs_s & uv_en_s)) && !otemp_s) |=> !rails_off); // R3

    AST_DIP_PG: assert property (@(posedge clk) disable iff (!rst_n)
        (|dip_s) |=> pg_low); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code == 2'b01 || fault_code == 2'b10) && !vin_low_s && !ctrl_clr)
        |=> $stable(fault_code)); // R5

    AST_VIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        vin_low_s |=> (!sr_force_on && fault_code != 2'b01 && fault_code != 2'b10)); // R8

    AST_THERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        otemp_s |=> rails_off); // R9

    AST_THERM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 2'b11 && !otemp_s && !(|ov_s) && !(|(uvs_s & uv_en_s)))
        |=> (fault_code == 2'b00 && !rails_off)); // R9

    AST_OV_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code == 2'b00 || fault_code == 2'b11) && |ov_s && |(uvs_s & uv_en_s)
         && !vin_low_s && !ctrl_clr) |=> (fault_code == 2'b01)); // R10
endmodule

bind rail_fault_supervisor rfs_checker #(.N_RAILS(N_RAILS)) u_rfs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ov_s       (ov_s),
    .uvs_s      (uvs_s),
    .uv_en_s    (uv_en_s),
    .dip_s      (dip_s),
    .otemp_s    (otemp_s),
    .vin_low_s  (vin_low_s),
    .ctrl_clr   (ctrl_clr),
    .fault_code (fault_code),
    .rails_off  (rails_off),
    .sr_force_on(sr_force_on),
    .pg_low     (pg_low)
);

// File: tb/test_rail_fault_supervisor.sv
module test_rail_fault_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ov_flag = '0, uvs_flag = '0, dip_flag = '0, uv_en = '0;
    logic       otemp = 1'b0, shdn_n = 1'b1, run_a = 1'b1, vin_low = 1'b0;
    logic [1:0] fault_code;
    logic       rails_off, sr_force_on, pg_low;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [1:0] code;
        logic       off;
        logic       sr;
        logic       pgl;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    rail_fault_supervisor i_rail_fault_supervisor (
        .clk(clk), .rst_n(rst_n),
        .ov_flag(ov_flag), .uvs_flag(uvs_flag), .dip_flag(dip_flag), .uv_en(uv_en),
        .otemp(otemp), .shdn_n(shdn_n), .run_a(run_a), .vin_low(vin_low),
        .fault_code(fault_code), .rails_off(rails_off),
        .sr_force_on(sr_force_on), .pg_low(pg_low)
    );

    task automatic check(input logic [1:0] code, input logic off, input logic sr,
                         input logic pgl, input string req);
        checks++;
        if (fault_code !== code || rails_off !== off || sr_force_on !== sr || pg_low !== pgl) begin
            errors++;
            $display("FAIL %s: got code=%b off=%b sr=%b pgl=%b, expected code=%b off=%b sr=%b pgl=%b",
                     req, fault_code, rails_off, sr_force_on, pg_low, code, off, sr, pgl);
        end
    endtask

    // driver: inputs already applied at a negedge; expected result is due after three edges
    task automatic step(input logic [1:0] code, input logic off, input logic sr,
                        input logic pgl, input string req);
        exp_t e;
        repeat (3) @(posedge clk);
        e.code = code; e.off = off; e.sr = sr; e.pgl = pgl; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.code, e.off, e.sr, e.pgl, e.req);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(2'b00, 1'b0, 1'b0, 1'b1, "R12 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        step(2'b00, 0, 0, 0, "R4 idle no dip");
        dip_flag = 2'b01;
        step(2'b00, 0, 0, 1, "R4 dip rail a");
        dip_flag = 2'b10;
        step(2'b00, 0, 0, 1, "R4 dip rail b");
        dip_flag = 2'b00;
        step(2'b00, 0, 0, 0, "R4 dip released");

        uvs_flag = 2'b10;
        step(2'b00, 0, 0, 0, "R3 uv masked");
        uv_en = 2'b10;
        step(2'b10, 1, 0, 1, "R2 uv latch");
        uvs_flag = 2'b00; uv_en = 2'b00;
        step(2'b10, 1, 0, 1, "R5 uv hold");
        shdn_n = 1'b0;
        step(2'b10, 1, 0, 1, "R6 fall alone");
        shdn_n = 1'b1;
        step(2'b00, 0, 0, 0, "R6 toggle clear");

        ov_flag = 2'b01;
        step(2'b01, 1, 1, 1, "R1 ov latch");
        ov_flag = 2'b00;
        step(2'b01, 1, 1, 1, "R5 ov hold");
        run_a = 1'b0;
        step(2'b01, 1, 1, 1, "R7 run fall");
        run_a = 1'b1;
        step(2'b00, 0, 0, 0, "R7 run toggle clear");

        ov_flag = 2'b10; uvs_flag = 2'b01; uv_en = 2'b01;
        step(2'b01, 1, 1, 1, "R10 ov wins tie");
        ov_flag = 2'b00; uvs_flag = 2'b00; uv_en = 2'b00; vin_low = 1'b1;
        step(2'b00, 0, 0, 0, "R8 vin clear");
        ov_flag = 2'b01;
        step(2'b00, 0, 0, 0, "R8 vin blocks latch");
        ov_flag = 2'b00; vin_low = 1'b0;
        step(2'b00, 0, 0, 0, "R8 after vin release");

        otemp = 1'b1;
        step(2'b11, 1, 0, 1, "R9 thermal on");
        otemp = 1'b0;
        step(2'b00, 0, 0, 0, "R9 thermal release");

        uvs_flag = 2'b01; uv_en = 2'b01;
        step(2'b10, 1, 0, 1, "R11 first uv");
        ov_flag = 2'b01;
        step(2'b10, 1, 1, 1, "R11 later ov keeps code");
        ov_flag = 2'b00; uvs_flag = 2'b00; uv_en = 2'b00; vin_low = 1'b1;
        step(2'b00, 0, 0, 0, "R8 vin clear again");
        vin_low = 1'b0;
        step(2'b00, 0, 0, 0, "R8 idle");

        ov_flag = 2'b10;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(2'b00, 0, 0, 0, "R13 no change after two edges");
        @(posedge clk);
        @(negedge clk);
        check(2'b01, 1, 1, 1, "R13 change on third edge");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule